// File: doc/BRIEF.md
# Self-Timed Byte-Wide Non-Volatile Store Controller

This block is the control and storage logic of a byte-wide non-volatile memory. A host drives it with SRAM-style strobes: active-low chip select, output enable and write strobe, an address and a data byte. A read is plain: when chip select and output enable are both low, the block drives the addressed byte.

A write takes many cycles. When the write strobe goes back high after a valid low pulse, the address and data are copied into internal latches and the host bus is free again. An internal timer then runs two phases: it first erases the target byte to all ones, then programs the latched value. While that runs, any read returns the inverse of the latched top bit in the top bit position. The host polls the written location until the true byte comes back.

If a bulk-select input is high during the write pulse, the block erases the whole array to all ones over a fixed number of cycles instead of writing one byte. Write pulses that are too short, pulses that arrive while the block is busy, and pulses seen while the supply-good input is low are all dropped.

Top module: `nvm_byte_store`

## Requirements
- R1: `dataDrive` is 1 exactly when `ceN` and `oeN` are both 0, and it is 0 in every other combination.
- R2: The address, data and bulk-select values present during the last low cycle of an accepted write pulse are the ones written. Bus values applied after the write strobe rises have no effect on the result.
- R3: A byte write is accepted on the first clock edge that samples `weN` high after it was low. A read of the written location returns the written byte from the (ERASE_CYC+PROG_CYC+1)-th falling clock edge after that accept edge, and not earlier.
- R4: While a write or clear sequence runs, a read of any address returns on its top data bit the inverse of the top bit of the latched data.
- R5: The target byte is erased before it is programmed. After ERASE_CYC cycles of a byte write, and before programming completes, the target location reads back with all lower bits set to 1.
- R6: A write with `bulkSel` = 1 sets every location to 8'hFF. A read returns the true byte from the (CLEAR_CYC+1)-th falling edge after the accept edge.
- R7: A write pulse that completes while a sequence is running is ignored. The running write finishes with its own latched address and data, and the address targeted by the second pulse keeps its old value.
- R8: A write pulse that completes while `supplyOk` = 0 changes no location and starts no sequence.
- R9: A write pulse is accepted only if `weN` was sampled low, with `ceN` low and `oeN` high, on at least MIN_WE_CYC consecutive rising edges. A shorter pulse changes no location and starts no sequence.
- R10: Each of the 2^ADDR_W locations stores its own byte independently of the others.
- R11: A `weN` low pulse while `ceN` is high starts no write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset of the control state. The array is not reset. |
| ceN | input | 1 | Active-low chip select |
| oeN | input | 1 | Active-low output enable |
| weN | input | 1 | Active-low write strobe |
| addr | input | ADDR_W | Byte address |
| dataIn | input | DATA_W | Write data from the host |
| bulkSel | input | 1 | When high during a write pulse, requests a whole-array clear |
| supplyOk | input | 1 | Supply good. When low, writes are inhibited. |
| dataOut | output | DATA_W | Read data, or polling status while busy |
| dataDrive | output | 1 | High when the data port is driven. When low, the port is high-impedance. |

## Verification
Two functions can act in the same cycle: the final program step of a write, and a status read of the same location. Both the poll and the array update are decided at one clock edge. The bench reads the target on every falling edge from the accept edge onward. It records the first edge at which the true byte appears and compares that edge number with ERASE_CYC+PROG_CYC+1, which is computed from the parameters. The bench also lands a second write pulse inside a running sequence and checks that only the first write reaches the array.

// File: rtl/nvm_pkg.sv
package nvm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ERASE,
    ST_PROG,
    ST_CLEAR
  } nvmState_t;

  typedef struct packed {
    logic shadowEn;
    logic latchEn;
    logic eraseByte;
    logic progByte;
    logic wipeAll;
    logic busy;
  } nvmStrobe_t;

endpackage

// File: rtl/nvm_ctrl.sv
module nvm_ctrl #(
  parameter int ERASE_CYC  = 100000,
  parameter int PROG_CYC   = 100000,
  parameter int CLEAR_CYC  = 200000,
  parameter int MIN_WE_CYC = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                ceN,
  input  logic                oeN,
  input  logic                weN,
  input  logic                supplyOk,
  input  logic                bulkSel,
  output nvm_pkg::nvmStrobe_t strb
);
  import nvm_pkg::*;

  localparam int MAX_EP   = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int MAX_CYC  = (MAX_EP > CLEAR_CYC) ? MAX_EP : CLEAR_CYC;
  localparam int CNT_W    = $clog2(MAX_CYC + 1);
  localparam int FILT_W   = $clog2(MIN_WE_CYC + 1);

  nvmState_t        state;
  logic [CNT_W-1:0] cnt;
  logic [FILT_W-1:0] lowCnt;
  logic             weNPrev;
  logic             clrPending;
  logic             weRise;
  logic             pulseOk;
  logic             accept;
  logic             eraseDone;
  logic             progDone;
  logic             clearDone;

  assign weRise    = weN && !weNPrev;
  assign pulseOk   = lowCnt >= FILT_W'(MIN_WE_CYC);
  assign accept    = (state == ST_IDLE) && weRise && pulseOk && supplyOk;
  assign eraseDone = (state == ST_ERASE) && (cnt == CNT_W'(ERASE_CYC - 1));
  assign progDone  = (state == ST_PROG)  && (cnt == CNT_W'(PROG_CYC - 1));
  assign clearDone = (state == ST_CLEAR) && (cnt == CNT_W'(CLEAR_CYC - 1));

  always_comb begin
    strb.shadowEn  = !weN && !ceN && oeN;
    strb.latchEn   = accept;
    strb.eraseByte = eraseDone;
    strb.progByte  = progDone;
    strb.wipeAll   = clearDone;
    strb.busy      = (state != ST_IDLE);
  end

  // Pulse filter: count qualified low cycles, judged when the strobe rises
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      weNPrev    <= 1'b1;
      lowCnt     <= '0;
      clrPending <= 1'b0;
    end else begin
      weNPrev <= weN;
      if (!(!weN && !ceN && oeN)) begin
        lowCnt <= '0;
      end else if (lowCnt != FILT_W'(MIN_WE_CYC)) begin
        lowCnt <= lowCnt + 1'b1;
      end
      if (!weN && !ceN && oeN) begin
        clrPending <= bulkSel;
      end
    end
  end

  // Sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (accept) begin
            state <= clrPending ? ST_CLEAR : ST_ERASE;
          end
        end
        ST_ERASE: begin
          if (eraseDone) begin
            state <= ST_PROG;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_PROG: begin
          if (progDone) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_CLEAR: begin
          if (clearDone) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          state <= ST_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/nvm_datapath.sv
module nvm_datapath #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  nvm_pkg::nvmStrobe_t strb,
  input  logic                ceN,
  input  logic                oeN,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   dataIn,
  output logic [DATA_W-1:0]   dataOut,
  output logic                dataDrive,
  output logic [ADDR_W-1:0]   latchAddr,
  output logic [DATA_W-1:0]   latchData
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int MSB   = DATA_W - 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] shadowAddr;
  logic [DATA_W-1:0] shadowData;
  logic [DATA_W-1:0] rdWord;

  // Bus capture while the strobe is low; latch on accept
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowAddr <= '0;
      shadowData <= '0;
      latchAddr  <= '0;
      latchData  <= '0;
    end else begin
      if (strb.shadowEn) begin
        shadowAddr <= addr;
        shadowData <= dataIn;
      end
      if (strb.latchEn) begin
        latchAddr <= shadowAddr;
        latchData <= shadowData;
      end
    end
  end

  // Storage array: not reset, it models non-volatile cells
  always_ff @(posedge clk) begin
    if (strb.wipeAll) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem[i] <= '1;
      end
    end else if (strb.eraseByte) begin
      mem[latchAddr] <= '1;
    end else if (strb.progByte) begin
      mem[latchAddr] <= latchData;
    end
  end

  assign rdWord    = mem[addr];
  assign dataDrive = !ceN && !oeN;

  always_comb begin
    if (strb.busy) begin
      dataOut = {~latchData[MSB], rdWord[MSB-1:0]};
    end else begin
      dataOut = rdWord;
    end
  end

endmodule

// File: rtl/nvm_byte_store.sv
module nvm_byte_store #(
  parameter int ADDR_W     = 11,
  parameter int DATA_W     = 8,
  parameter int ERASE_CYC  = 100000,
  parameter int PROG_CYC   = 100000,
  parameter int CLEAR_CYC  = 200000,
  parameter int MIN_WE_CYC = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              bulkSel,
  input  logic              supplyOk,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataDrive
);

  nvm_pkg::nvmStrobe_t strb;
  logic [ADDR_W-1:0]   latchAddr;
  logic [DATA_W-1:0]   latchData;

  nvm_ctrl #(
    .ERASE_CYC (ERASE_CYC),
    .PROG_CYC  (PROG_CYC),
    .CLEAR_CYC (CLEAR_CYC),
    .MIN_WE_CYC(MIN_WE_CYC)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .ceN     (ceN),
    .oeN     (oeN),
    .weN     (weN),
    .supplyOk(supplyOk),
    .bulkSel (bulkSel),
    .strb    (strb)
  );

  nvm_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .ceN      (ceN),
    .oeN      (oeN),
    .addr     (addr),
    .dataIn   (dataIn),
    .dataOut  (dataOut),
    .dataDrive(dataDrive),
    .latchAddr(latchAddr),
    .latchData(latchData)
  );

endmodule

// File: rtl/nvm_byte_store_chk.sv
module nvm_byte_store_chk #(
  parameter int ADDR_W    = 11,
  parameter int DATA_W    = 8,
  parameter int ERASE_CYC = 100000,
  parameter int PROG_CYC  = 100000,
  parameter int CLEAR_CYC = 200000
) (
  input logic                clk,
  input logic                rstN,
  input logic                ceN,
  input logic                oeN,
  input logic                supplyOk,
  input logic                dataDrive,
  input nvm_pkg::nvmStrobe_t strb,
  input logic [ADDR_W-1:0]   latchAddr,
  input logic [DATA_W-1:0]   latchData
);

  int   runLen;
  logic sawErase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runLen   <= 0;
      sawErase <= 1'b0;
    end else begin
      runLen <= strb.busy ? runLen + 1 : 0;
      if (strb.eraseByte) begin
        sawErase <= 1'b1;
      end else if (strb.progByte) begin
        sawErase <= 1'b0;
      end
    end
  end

  assert_no_drive_R1: assert property (@(posedge clk) disable iff (!rstN)
    (ceN || oeN) |-> !dataDrive);

  assert_capture_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    strb.shadowEn |-> !dataDrive);

  assert_latch_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.busy && $past(strb.busy)) |-> ($stable(latchAddr) && $stable(latchData)));

  assert_run_length_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strb.busy) |-> (runLen == ERASE_CYC + PROG_CYC || runLen == CLEAR_CYC));

  assert_erase_first_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.progByte |-> sawErase);

  assert_one_action_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.eraseByte, strb.progByte, strb.wipeAll}));

  assert_idle_accept_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.latchEn |-> !strb.busy);

  assert_supply_gate_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strb.busy) |-> $past(supplyOk));

endmodule

bind nvm_byte_store nvm_byte_store_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .ERASE_CYC(ERASE_CYC),
  .PROG_CYC (PROG_CYC),
  .CLEAR_CYC(CLEAR_CYC)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .ceN      (ceN),
  .oeN      (oeN),
  .supplyOk (supplyOk),
  .dataDrive(dataDrive),
  .strb     (strb),
  .latchAddr(latchAddr),
  .latchData(latchData)
);

// File: tb/tb_nvm_byte_store.sv
`timescale 1ns/1ps
module tb_nvm_byte_store;

  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam int ECYC   = 6;
  localparam int PCYC   = 10;
  localparam int CCYC   = 20;
  localparam int MINW   = 3;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rstN;
  logic              ceN, oeN, weN, bulkSel, supplyOk;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] dataIn;
  logic [DATA_W-1:0] dataOut;
  logic              dataDrive;

  int cmpCnt = 0;
  int errCnt = 0;
  logic [7:0] mdl [DEPTH];

  always #2.5 clk = ~clk;

  nvm_byte_store #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ERASE_CYC(ECYC),
    .PROG_CYC(PCYC), .CLEAR_CYC(CCYC), .MIN_WE_CYC(MINW)
  ) dut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN),
    .addr(addr), .dataIn(dataIn), .bulkSel(bulkSel), .supplyOk(supplyOk),
    .dataOut(dataOut), .dataDrive(dataDrive)
  );

  task automatic chk(input string tag, input int act, input int exp);
    cmpCnt++;
    if (act != exp) begin
      errCnt++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input int a, output logic [7:0] v);
    @(negedge clk);
    ceN = 1'b0; oeN = 1'b0; weN = 1'b1; addr = ADDR_W'(a);
    #1;
    v = dataOut;
  endtask

  // Low pulse of lowCyc sampled edges; returns at the edge before accept
  task automatic wr(input int a, input int d, input int lowCyc, input logic bulk, input logic cs);
    @(negedge clk);
    ceN = cs; oeN = 1'b1; weN = 1'b0; addr = ADDR_W'(a); dataIn = 8'(d); bulkSel = bulk;
    repeat (lowCyc) @(negedge clk);
    weN = 1'b1;
  endtask

  // Poll location a; n counts falling edges after the accept edge
  task automatic pollDone(input int a, input int exp, input int expN, input string tag);
    int doneN = 0;
    for (int n = 1; n <= 400; n++) begin
      @(negedge clk);
      ceN = 1'b0; oeN = 1'b0; weN = 1'b1; bulkSel = 1'b0;
      addr = (n == 1) ? ADDR_W'(a ^ 1) : ADDR_W'(a);
      dataIn = ~8'(exp);
      #1;
      if (n == 1) begin
        chk({"R4 poll top bit ", tag}, int'(dataOut[7]), int'(~exp[7] & 1));
      end else begin
        if (n == ECYC + 1 && expN == ECYC + PCYC + 1) begin
          chk({"R5 erased before program ", tag}, int'(dataOut[6:0]), 'h7F);
        end
        if (dataOut == 8'(exp)) begin
          doneN = n;
          break;
        end
      end
    end
    if (expN != 0) chk({"R3/R6 completion edge ", tag}, doneN, expN);
    else chk({"R7 completes ", tag}, int'(doneN != 0), 1);
  endtask

  initial begin
    logic [7:0] v;
    rstN = 1'b0; ceN = 1'b1; oeN = 1'b1; weN = 1'b1; bulkSel = 1'b0;
    supplyOk = 1'b1; addr = '0; dataIn = '0;
    repeat (4) @(negedge clk);
    #1;
    chk("R1 no drive in reset idle", int'(dataDrive), 0);
    rstN = 1'b1;

    // R1: all four select combinations
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      ceN = k[0]; oeN = k[1];
      #1;
      chk("R1 drive vs selects", int'(dataDrive), int'(k == 0));
    end

    // R6: whole-array clear, then check every location
    wr(2, 'hFF, MINW, 1'b1, 1'b0);
    pollDone(5, 'hFF, CCYC + 1, "clear");
    for (int a = 0; a < DEPTH; a++) begin
      rd(a, v);
      chk("R6 location erased", int'(v), 'hFF);
      mdl[a] = 8'hFF;
    end

    // R10/R2/R3/R4/R5: sweep every address
    for (int a = 0; a < DEPTH; a++) begin
      int d = (a * 37 + 11) & 'hFF;
      wr(a, d, MINW, 1'b0, 1'b0);
      pollDone(a, d, ECYC + PCYC + 1, "sweep");
      mdl[a] = 8'(d);
    end
    for (int a = 0; a < DEPTH; a++) begin
      rd(a, v);
      chk("R10 readback", int'(v), int'(mdl[a]));
    end

    // R9: one cycle short is dropped, exact minimum is taken
    wr(3, 'h5A, MINW - 1, 1'b0, 1'b0);
    rd(3, v);
    chk("R9 short pulse dropped", int'(v), int'(mdl[3]));
    wr(3, 'h5A, MINW, 1'b0, 1'b0);
    pollDone(3, 'h5A, ECYC + PCYC + 1, "min pulse R9");
    mdl[3] = 8'h5A;

    // R8: supply low inhibits
    supplyOk = 1'b0;
    wr(4, 'h33, MINW + 2, 1'b0, 1'b0);
    rd(4, v);
    chk("R8 inhibited write", int'(v), int'(mdl[4]));
    rd(4, v);
    chk("R8 no sequence", int'(v), int'(mdl[4]));
    supplyOk = 1'b1;

    // R11: strobe with chip deselected
    wr(5, 'h21, MINW + 2, 1'b0, 1'b1);
    rd(5, v);
    chk("R11 deselected write", int'(v), int'(mdl[5]));

    // R7: second write inside a running sequence
    wr(6, 'hC3, MINW, 1'b0, 1'b0);
    wr(7, 'h3C, MINW, 1'b0, 1'b0);
    pollDone(6, 'hC3, 0, "first of pair");
    mdl[6] = 8'hC3;
    rd(7, v);
    chk("R7 second target untouched", int'(v), int'(mdl[7]));
    rd(6, v);
    chk("R7 first data kept", int'(v), 'hC3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", cmpCnt, errCnt);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errCnt++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", cmpCnt, errCnt);
    $finish;
  end

endmodule